// File: doc/BRIEF.md
# Transport stream packet output formatter

The formatter sits after the error-correction and descrambling stages of a broadcast receiver. It takes one transport-stream byte per accepted input beat, together with a per-packet "uncorrectable" flag and a descrambler-lock status. It finds packet alignment by looking for the sync byte 0x47 at packet-length spacing. Once alignment is found, it forwards packets either as whole bytes on an 8-bit bus or one bit at a time on bit 0 of that bus.

While forwarding, it can force the transport error indicator in each damaged packet's header. It also drives an error-indicator line that has a selectable polarity and two hold behaviours. An output clock is derived from the block clock, and its launching edge can be selected.

All configuration comes from a static control word `ctrl`:

| Bits | Field | Meaning |
|------|-------|---------|
| [2:0] | lock threshold | lock needs this value + 2 good sync bytes; 3 (5 sync bytes) is the usual setting |
| [3] | serial | 1 selects bit-serial output |
| [4] | header marking | 1 enables forcing of the error bit in the header |
| [5] | clock invert | selects the output clock edge |
| [6] | error polarity | 1 inverts the error line |
| [7] | latched error mode | 1 selects latched mode, 0 selects packet-hold mode |
| [8] | short packets | 1 selects 130-byte packets, 0 selects 188-byte packets |

Top module: `ts_out_fmt`

## Requirements
- R1: Packet bytes are accepted when `in_valid` and `in_ready` are both high. The aligner begins tracking on any accepted 0x47. At each later expected sync position (one packet length on) it counts a further 0x47. Lock is declared on the sync byte that brings the count to `ctrl[2:0]`+2. That sync byte is the first byte output, and no byte is output before lock.
- R2: If an expected sync position does not carry 0x47, tracking and lock are dropped and the count clears. That byte is not output, and the search restarts from the following bytes.
- R3: The uncorrectable flag is sampled with each packet's sync byte. When `ctrl[4]`=1 and that flag is 1, bit 7 of packet byte index 1 (the byte after the sync byte) is output as 1. Otherwise every byte is output unchanged.
- R4: In parallel mode (`ctrl[3]`=0), each output byte appears on `out_data` in the cycle after it is accepted, with a one-cycle `out_valid`. `out_start` is also high when the byte is a packet's sync byte. `in_ready` stays high.
- R5: In serial mode (`ctrl[3]`=1), each output byte is sent MSB first on `out_data[0]` over 8 cycles, starting the cycle after acceptance, and `out_data[7:1]` is 0. `out_valid` is high only in the first-bit cycle. `in_ready` is low during bits 7 to 1 and high during bit 0.
- R6: `out_clk` equals `clk` when `ctrl[5]`=0, so data changes on its rising edge. When `ctrl[5]`=1 it is the inverse of `clk`, so data changes on its falling edge.
- R7: In packet-hold mode (`ctrl[7]`=0), the internal error state is updated only when a sync byte is output. It then takes that packet's uncorrectable flag, so an error lasts through the packet's last byte and until the next output packet starts.
- R8: In latched mode (`ctrl[7]`=1), the error state becomes active the cycle after `desc_lock` is sampled low, and also on an output sync byte whose packet is flagged. It clears only when an unflagged packet's sync byte is output while `desc_lock` is high.
- R9: `out_err` is high when there is no error and low on error with `ctrl[6]`=0. `ctrl[6]`=1 inverts it. After reset there is no error.
- R10: `ctrl[8]` selects the packet length (0: 188 bytes, 1: 130 bytes). The length sets both the sync spacing and the end of each packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl | input | 9 | Control word (field layout above) |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input transport-stream byte |
| in_uncorr | input | 1 | Packet uncorrectable flag, sampled with the sync byte |
| desc_lock | input | 1 | Descrambler lock status |
| in_ready | output | 1 | Block can accept a byte |
| out_data | output | 8 | Parallel byte, or the serial bit on bit 0 |
| out_valid | output | 1 | New byte (parallel) or first bit of a byte (serial) |
| out_start | output | 1 | Output byte is a packet sync byte |
| out_err | output | 1 | Error indicator, polarity set by `ctrl[6]` |
| out_clk | output | 1 | Output clock |

## Verification
The bench aims at the exact lock boundary: no output after threshold+1 sync bytes, and output on the next one. An off-by-one in the count would start a packet early or late. It breaks the sync pattern while locked and then checks that the broken packet's bytes never appear. It compares the error line across both hold modes at packet edges and under a lock drop mid-packet; a design that cleared early or latched in the wrong mode would mismatch on the sync byte of the following packet. The serial check walks every bit of a marked header byte, which exposes bit-order, strobe-placement and pacing faults.

// File: rtl/ts_out_fmt.sv
module ts_out_fmt #(
  parameter int LONG_LEN  = 188,
  parameter int SHORT_LEN = 130,
  parameter logic [7:0] SYNC = 8'h47
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [8:0] ctrl,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_uncorr,
  input  logic       desc_lock,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_start,
  output logic       out_err,
  output logic       out_clk
);
  localparam int PW = $clog2(LONG_LEN);

  logic          trk, locked, bad, err, vreg, freg;
  logic [3:0]    cnt;
  logic [PW-1:0] pos;
  logic [7:0]    dreg;
  logic [2:0]    sc;

  wire [PW-1:0] last    = ctrl[8] ? PW'(SHORT_LEN - 1) : PW'(LONG_LEN - 1);
  wire          take    = in_valid && in_ready;
  wire          hit     = in_data == SYNC;
  wire          at_sync = trk && pos == '0;
  wire [3:0]    cnt_inc = (cnt == 4'hF) ? cnt : cnt + 4'd1;
  wire          lock_now = at_sync && hit && (cnt_inc >= 4'(ctrl[2:0]) + 4'd2);
  wire          keep    = locked && !(at_sync && !hit);
  wire          emit    = take && (keep || lock_now);
  wire          first   = at_sync && hit;
  wire          mark    = ctrl[4] && bad && pos == PW'(1);
  wire [7:0]    obyte   = in_data | {mark, 7'b0};

  assign in_ready  = sc == 3'd0;
  assign out_data  = ctrl[3] ? {7'b0, dreg[7]} : dreg;
  assign out_valid = vreg;
  assign out_start = freg;
  assign out_err   = ctrl[6] ? err : ~err;
  assign out_clk   = clk ^ ctrl[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk <= 1'b0; locked <= 1'b0; bad <= 1'b0; cnt <= '0; pos <= '0;
    end else if (take) begin
      if (!trk) begin
        if (hit) begin
          trk <= 1'b1; cnt <= 4'd1; pos <= PW'(1);
        end
      end else if (at_sync && !hit) begin
        trk <= 1'b0; locked <= 1'b0; cnt <= '0; pos <= '0;
      end else begin
        if (at_sync) begin
          cnt <= cnt_inc;
          bad <= in_uncorr;
        end
        if (lock_now) locked <= 1'b1;
        pos <= (pos >= last) ? '0 : pos + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg <= '0; sc <= '0; vreg <= 1'b0; freg <= 1'b0; err <= 1'b0;
    end else begin
      vreg <= emit;
      freg <= emit && first;
      if (emit) begin
        dreg <= obyte;
        sc   <= ctrl[3] ? 3'd7 : 3'd0;
      end else if (sc != 3'd0) begin
        dreg <= {dreg[6:0], 1'b0};
        sc   <= sc - 3'd1;
      end
      if (ctrl[7] && !desc_lock) err <= 1'b1;
      else if (emit && first)    err <= in_uncorr;
    end
  end

  a_r1_out_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> locked);
  a_r1_lock_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_data) == SYNC);
  a_r3_mark_header: assert property (@(posedge clk) disable iff (!rst_n)
    (take && keep && !ctrl[3] && ctrl[4] && bad && pos == PW'(1)) |=> out_data[7]);
  a_r5_serial_pace: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && ctrl[3]) |=> !in_ready);
  a_r8_latch_on_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7] && !desc_lock) |=> err);
  a_r7_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!(emit && first) && !(ctrl[7] && !desc_lock)) |=> $stable(err));
endmodule

// File: tb/ts_out_fmt_tb_top.sv
module ts_out_fmt_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [8:0] ctrl = 9'h003;
  logic in_valid = 1'b0, in_uncorr = 1'b0, desc_lock = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_start, out_err, out_clk;
  logic [7:0] out_data;

  ts_out_fmt dut_i (.clk(clk), .rst_n(rst_n), .ctrl(ctrl), .in_valid(in_valid),
    .in_data(in_data), .in_uncorr(in_uncorr), .desc_lock(desc_lock), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_start(out_start), .out_err(out_err),
    .out_clk(out_clk));

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0, starts = 0;
  bit m_trk = 0, m_lock = 0, m_bad = 0, m_err = 0, e_v = 0, e_f = 0;
  int m_cnt = 0, m_pos = 0;
  logic [7:0] e_d = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_err_line();
    return ctrl[6] ? m_err : !m_err;
  endfunction

  task automatic model(input logic [7:0] b, input bit v, input bit unc, input bit dl);
    int plen = ctrl[8] ? 130 : 188;
    int thr = int'(ctrl[2:0]) + 2;
    e_v = 0; e_f = 0;
    if (v) begin
      if (!m_trk) begin
        if (b == 8'h47) begin m_trk = 1; m_cnt = 1; m_pos = 1; end
      end else if (m_pos == 0) begin
        if (b != 8'h47) begin
          m_trk = 0; m_lock = 0; m_cnt = 0;
        end else begin
          m_cnt = (m_cnt < 15) ? m_cnt + 1 : 15;
          m_bad = unc;
          if (m_cnt >= thr) m_lock = 1;
          if (m_lock) begin e_v = 1; e_f = 1; e_d = b; end
          m_pos = 1;
        end
      end else begin
        if (m_lock) begin
          e_v = 1;
          e_d = (m_pos == 1 && ctrl[4] && m_bad) ? (b | 8'h80) : b;
        end
        m_pos = (m_pos >= plen - 1) ? 0 : m_pos + 1;
      end
    end
    if (ctrl[7] && !dl) m_err = 1;
    else if (e_f) m_err = unc;
  endtask

  task automatic step(input logic [7:0] b, input bit v, input bit unc, input bit dl, input string tag);
    in_data = b; in_valid = v; in_uncorr = unc; desc_lock = dl;
    model(b, v, unc, dl);
    @(posedge clk); @(negedge clk);
    if (out_start) starts++;
    chk(out_valid == e_v, {tag, " R4 valid"}, out_valid, e_v);
    if (e_v) begin
      chk(out_data == e_d, {tag, " data"}, out_data, e_d);
      chk(out_start == e_f, {tag, " R4 start"}, out_start, e_f);
    end
    chk(out_err == exp_err_line(), {tag, " err line"}, out_err, exp_err_line());
  endtask

  task automatic pkt(input logic [7:0] syncb, input bit unc, input bit dl, input string tag,
                     input bit full_rand = 0);
    int plen = ctrl[8] ? 130 : 188;
    for (int i = 0; i < plen; i++) begin
      logic [7:0] b;
      b = full_rand ? 8'($urandom) : (8'($urandom) & 8'h3F);
      step(i == 0 ? syncb : b, 1'b1, unc, dl, tag);
    end
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    m_trk = 0; m_lock = 0; m_bad = 0; m_err = 0; m_cnt = 0; m_pos = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    chk(out_valid == 0, "reset R4 valid", out_valid, 0);
    chk(out_err == 1, "reset R9 err", out_err, 1);
    chk(in_ready == 1, "reset R4 ready", in_ready, 1);

    // R1: threshold 3 -> fifth sync locks
    starts = 0;
    for (int p = 0; p < 4; p++) pkt(8'h47, 0, 1, "R1 prelock");
    chk(starts == 0, "R1 no start before lock", starts, 0);
    pkt(8'h47, 0, 1, "R1 lock");
    chk(starts == 1, "R1 start on fifth sync", starts, 1);

    // R3 / R7: flagged packet, marking off then on
    pkt(8'h47, 1, 1, "R7 hold flagged, R3 unmarked");
    ctrl[4] = 1'b1;
    pkt(8'h47, 1, 1, "R3 marked");
    pkt(8'h47, 0, 1, "R7 clears on clean");

    // R8: latched mode
    ctrl[7] = 1'b1;
    pkt(8'h47, 0, 0, "R8 unlock sets");
    pkt(8'h47, 0, 1, "R8 clean clears");
    ctrl[7] = 1'b0;

    // R9: inverted polarity
    ctrl[6] = 1'b1;
    pkt(8'h47, 1, 1, "R9 inverted flagged");
    pkt(8'h47, 0, 1, "R9 inverted clean");
    ctrl[6] = 1'b0;

    // R2: broken sync drops lock
    starts = 0;
    pkt(8'h12, 0, 1, "R2 broken sync");
    chk(starts == 0, "R2 no output after miss", starts, 0);
    pkt(8'h47, 0, 1, "R2 relock search");

    // R10: short packets, threshold 0
    do_reset();
    ctrl = 9'h100;
    starts = 0;
    for (int p = 0; p < 3; p++) pkt(8'h47, p == 2, 1, "R10 short");
    chk(starts == 2, "R10 short packet starts", starts, 2);

    // R6: output clock edge
    chk(out_clk == 1'b0, "R6 clk normal", out_clk, 0);
    ctrl[5] = 1'b1; #1;
    chk(out_clk == 1'b1, "R6 clk inverted", out_clk, 1);
    ctrl[5] = 1'b0;

    // random mix
    for (int p = 0; p < 40; p++) begin
      int r = $urandom_range(0, 99);
      if (p % 8 == 0) ctrl = {1'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'($urandom), 1'b0, 3'($urandom)};
      pkt(r < 6 ? 8'h33 : 8'h47, 1'($urandom), r < 90, "R1 R2 R7 R8 random", 1'b1);
    end

    // R5: serial output, locked on short packets
    do_reset();
    ctrl = 9'h110;
    for (int p = 0; p < 2; p++) pkt(8'h47, 0, 1, "R5 prelock");
    ctrl[3] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      logic [7:0] b;
      b = (k == 0) ? 8'h47 : (k == 1 ? 8'h05 : 8'h5A);
      chk(in_ready == 1, "R5 ready idle", in_ready, 1);
      in_data = b; in_valid = 1'b1; in_uncorr = 1'b1;
      model(b, 1'b1, 1'b1, 1'b1);
      @(posedge clk);
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_data == {7'b0, e_d[7 - j]}, "R5 bit", out_data, {7'b0, e_d[7 - j]});
        chk(out_valid == (j == 0), "R5 strobe", out_valid, j == 0);
        chk(in_ready == (j == 7), "R5 pacing", in_ready, j == 7);
      end
      if (k == 1) chk(e_d == 8'h85, "R5 R3 serial marked", e_d, 8'h85);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule